// File: doc/BRIEF.md
# Tamper Detector with Backup Register Erase

This block watches a set of tamper input pins. When an enabled pin shows a tamper, it sets that pin's own flag and zeroes a small bank of backup registers in the same clock edge. It can also raise an interrupt and send a one-clock request to a time-stamp unit. Each pin has its own enable, its own active polarity and its own choice of detector. A pin can use an edge detector, which fires on the first synchronized transition to the active level. It can instead use a level detector, which fires only after the pin has stayed at its active level for a selectable number of consecutive sample ticks.

The backup bank is a word-addressed register file with a registered read port. It is cleared by the power-on reset or by a tamper event, and nothing else clears it. The system reset clears the detectors, the flags and the outputs, but the stored words survive it. Software clears flags through per-input write-zero strobes.

Top module: `tamper_guard`

## Requirements
- R1: An input whose `tamp_en` bit is 0 never sets its flag and never erases the backup bank, whatever its pin does.
- R2: In edge mode (`tamp_level` bit 0), a transition to the active level sets the flag on the third rising clock edge after the pin changes (two synchronizer stages plus one detector stage). A pin that stays active after its flag is cleared does not set the flag again.
- R3: In level mode (`tamp_level` bit 1), a tamper is declared after N consecutive `samp_tick` samples at the active level. N is 2 for `filt_sel`=00, 4 for 01, and 8 for 10 or 11. With `samp_tick` held high, the flag sets on clock edge N+2 after the pin change, and a shorter pulse sets nothing and leaves the bank intact.
- R4: When the `tamp_pol` bit is 1, the input is active high. When it is 0, the input is active low, so an idle-high pin tampers on its falling transition and its rising transition is ignored.
- R5: Every tamper event zeroes all backup words, on the same clock edge that sets the flag.
- R6: A backup write presented in the same cycle as a tamper erase is discarded, and the word reads 0 afterwards.
- R7: `tamp_irq` is registered. It is 1 one clock after any flag is 1 while `irq_en` is 1, and it stays 0 while `irq_en` is 0.
- R8: When `ts_on_tamp` is 1, `ts_req` is 1 for one clock, coinciding with the flag being set. When `ts_on_tamp` is 0, `ts_req` stays 0.
- R9: A 1 on a `flag_clr` bit clears that flag on the next edge. A tamper event in the same cycle wins, and the flag stays set.
- R10: `sys_rst` clears the flags, `tamp_irq`, `ts_req` and the detector state, and keeps the backup words. `por_rst` also clears every backup word and `bk_rdata`.
- R11: `bk_rdata` returns the word at `bk_addr` one clock after the address is presented. A write is stored on the edge at which `bk_we` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and system clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high; clears everything |
| sys_rst | input | 1 | System reset, synchronous, active high; backup words kept |
| tamp_pin | input | NUM_IN | Asynchronous tamper pins |
| tamp_en | input | NUM_IN | Per-input detection enable |
| tamp_pol | input | NUM_IN | Per-input active level, 1 = high |
| tamp_level | input | NUM_IN | Per-input mode, 0 = edge, 1 = filtered level |
| filt_sel | input | 2 | Level filter length select (2/4/8 samples) |
| samp_tick | input | 1 | Sample strobe for the level filter |
| irq_en | input | 1 | Interrupt enable |
| ts_on_tamp | input | 1 | Request a time-stamp on a tamper event |
| flag_clr | input | NUM_IN | Per-input flag clear strobes |
| bk_we | input | 1 | Backup write enable |
| bk_addr | input | ADDR_W | Backup word address |
| bk_wdata | input | DATA_W | Backup write data |
| bk_rdata | output | DATA_W | Registered backup read data |
| tamp_flag | output | NUM_IN | Per-input tamper flags |
| tamp_irq | output | 1 | Registered tamper interrupt |
| ts_req | output | 1 | One-clock time-stamp capture request |

## Verification
The bench builds the block with its defaults: three inputs, eight 32-bit backup words. With three inputs, the edge detector, the level filter and the active-low polarity each run on their own pin, with no interference between them. `samp_tick` is held high, so the 2, 4 and 8 sample filter lengths become exact clock counts and the first cycle of each flag can be checked. Eight words are enough to confirm that an erase reaches words other than the one last written. They also allow a write to be aimed at the exact edge of an erase.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam int CNT_W = 4;
  typedef logic [CNT_W-1:0] cnt_t;

  // filter length in samples for the global filter select
  function automatic cnt_t filt_len(input logic [1:0] sel);
    case (sel)
      2'b00:   return cnt_t'(2);
      2'b01:   return cnt_t'(4);
      default: return cnt_t'(8);
    endcase
  endfunction
endpackage

// File: rtl/tamper_sync.sv
module tamper_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/tamper_detect.sv
module tamper_detect
  import tamper_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic act,
  input  logic en,
  input  logic level,
  input  logic tick,
  input  cnt_t lim,
  output logic hit
);
  logic act_d;
  cnt_t run;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_d <= 1'b0;
      run   <= '0;
    end else begin
      act_d <= act;
      if (!en || !level) begin
        run <= '0;
      end else if (tick) begin
        if (!act)          run <= '0;
        else if (run < lim) run <= run + cnt_t'(1);
      end
    end
  end

  always_comb begin
    if (!en)        hit = 1'b0;
    else if (level) hit = tick & act & (run == lim - cnt_t'(1));
    else            hit = act & ~act_d;
  end
endmodule

// File: rtl/backup_bank.sv
module backup_bank #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              erase,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (por_rst || erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (por_rst) rdata <= '0;
    else         rdata <= mem[addr];
  end
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
  import tamper_pkg::*;
#(
  parameter int NUM_IN = 3,
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              sys_rst,
  input  logic [NUM_IN-1:0] tamp_pin,
  input  logic [NUM_IN-1:0] tamp_en,
  input  logic [NUM_IN-1:0] tamp_pol,
  input  logic [NUM_IN-1:0] tamp_level,
  input  logic [1:0]        filt_sel,
  input  logic              samp_tick,
  input  logic              irq_en,
  input  logic              ts_on_tamp,
  input  logic [NUM_IN-1:0] flag_clr,
  input  logic              bk_we,
  input  logic [ADDR_W-1:0] bk_addr,
  input  logic [DATA_W-1:0] bk_wdata,
  output logic [DATA_W-1:0] bk_rdata,
  output logic [NUM_IN-1:0] tamp_flag,
  output logic              tamp_irq,
  output logic              ts_req
);
  logic              core_rst;
  logic [NUM_IN-1:0] act_raw;
  logic [NUM_IN-1:0] act_sync;
  logic [NUM_IN-1:0] tamp_hit;
  cnt_t              lim;

  assign core_rst = por_rst | sys_rst;
  // fold polarity in ahead of the synchronizer: reset state means inactive
  assign act_raw  = tamp_pin ^ ~tamp_pol;
  assign lim      = filt_len(filt_sel);

  tamper_sync #(.W(NUM_IN)) u_sync (
    .clk (clk),
    .rst (core_rst),
    .d   (act_raw),
    .q   (act_sync)
  );

  for (genvar g = 0; g < NUM_IN; g++) begin : g_det
    tamper_detect u_det (
      .clk   (clk),
      .rst   (core_rst),
      .act   (act_sync[g]),
      .en    (tamp_en[g]),
      .level (tamp_level[g]),
      .tick  (samp_tick),
      .lim   (lim),
      .hit   (tamp_hit[g])
    );
  end

  always_ff @(posedge clk) begin
    if (core_rst) begin
      tamp_flag <= '0;
      tamp_irq  <= 1'b0;
      ts_req    <= 1'b0;
    end else begin
      tamp_flag <= (tamp_flag & ~flag_clr) | tamp_hit;
      tamp_irq  <= irq_en & (|tamp_flag);
      ts_req    <= ts_on_tamp & (|tamp_hit);
    end
  end

  backup_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_bank (
    .clk     (clk),
    .por_rst (por_rst),
    .erase   (|tamp_hit),
    .we      (bk_we),
    .addr    (bk_addr),
    .wdata   (bk_wdata),
    .rdata   (bk_rdata)
  );
endmodule

// File: rtl/tamper_guard_chk.sv
module tamper_guard_chk #(
  parameter int NUM_IN = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              por_rst,
  input logic              sys_rst,
  input logic [NUM_IN-1:0] tamp_en,
  input logic [NUM_IN-1:0] flag_clr,
  input logic              irq_en,
  input logic              ts_on_tamp,
  input logic              bk_we,
  input logic [DATA_W-1:0] bk_rdata,
  input logic [NUM_IN-1:0] tamp_flag,
  input logic              tamp_irq,
  input logic              ts_req,
  input logic [NUM_IN-1:0] tamp_hit
);
  AST_DISABLED_NO_FLAG: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    ((tamp_flag & ~$past(tamp_flag) & ~$past(tamp_en)) == '0)); // R1

  AST_ERASE_ZEROES: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    ($past(|tamp_hit, 2) && !$past(bk_we, 2) && !$past(bk_we)) |-> (bk_rdata == '0)); // R5

  AST_ERASE_BEATS_WRITE: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    ($past(|tamp_hit, 2) && $past(bk_we, 2) && !$past(bk_we)) |-> (bk_rdata == '0)); // R6

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    tamp_irq == ($past(irq_en) && ($past(tamp_flag) != '0))); // R7

  AST_TS_NEEDS_FLAG: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    ts_req |-> ($past(ts_on_tamp) && (tamp_flag != '0))); // R8

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    ((tamp_flag & $past(tamp_flag & flag_clr) & ~$past(tamp_hit)) == '0)); // R9

  AST_SYSRST_QUIET: assert property (@(posedge clk) disable iff (por_rst)
    $past(sys_rst) |-> ((tamp_flag == '0) && !tamp_irq && !ts_req)); // R10
endmodule

bind tamper_guard tamper_guard_chk #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .por_rst    (por_rst),
  .sys_rst    (sys_rst),
  .tamp_en    (tamp_en),
  .flag_clr   (flag_clr),
  .irq_en     (irq_en),
  .ts_on_tamp (ts_on_tamp),
  .bk_we      (bk_we),
  .bk_rdata   (bk_rdata),
  .tamp_flag  (tamp_flag),
  .tamp_irq   (tamp_irq),
  .ts_req     (ts_req),
  .tamp_hit   (tamp_hit)
);

// File: tb/tb_tamper_guard.sv
module tb_tamper_guard;
  localparam int NUM_IN = 3;
  localparam int DEPTH  = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              por_rst, sys_rst;
  logic [NUM_IN-1:0] tamp_pin, tamp_en, tamp_pol, tamp_level, flag_clr;
  logic [1:0]        filt_sel;
  logic              samp_tick, irq_en, ts_on_tamp, bk_we;
  logic [ADDR_W-1:0] bk_addr;
  logic [DATA_W-1:0] bk_wdata, bk_rdata;
  logic [NUM_IN-1:0] tamp_flag;
  logic              tamp_irq, ts_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tamper_guard #(.NUM_IN(NUM_IN), .DEPTH(DEPTH), .DATA_W(DATA_W)) dut (
    .clk(clk), .por_rst(por_rst), .sys_rst(sys_rst), .tamp_pin(tamp_pin),
    .tamp_en(tamp_en), .tamp_pol(tamp_pol), .tamp_level(tamp_level),
    .filt_sel(filt_sel), .samp_tick(samp_tick), .irq_en(irq_en),
    .ts_on_tamp(ts_on_tamp), .flag_clr(flag_clr), .bk_we(bk_we),
    .bk_addr(bk_addr), .bk_wdata(bk_wdata), .bk_rdata(bk_rdata),
    .tamp_flag(tamp_flag), .tamp_irq(tamp_irq), .ts_req(ts_req)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bk_we = 1'b1; bk_addr = ADDR_W'(a); bk_wdata = d;
    step(1);
    bk_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bk_addr = ADDR_W'(a);
    step(1);
    d = bk_rdata;
  endtask

  task automatic clear_all();
    flag_clr = '1; step(1); flag_clr = '0; step(1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    por_rst = 1'b1; sys_rst = 1'b1; step(3);
    por_rst = 1'b0; sys_rst = 1'b0; step(1);
    chk("R10", "flags after reset", 32'(tamp_flag), 0);
    chk("R10", "irq after reset", 32'(tamp_irq), 0);
    chk("R10", "ts_req after reset", 32'(ts_req), 0);
    rd(6, d);
    chk("R10", "bank word after reset", d, 0);
  endtask

  task automatic t_bank();
    logic [31:0] d;
    wr(3, 32'hA5A5_0F0F);
    wr(5, 32'h0000_1234);
    rd(3, d); chk("R11", "read word 3", d, 32'hA5A5_0F0F);
    rd(5, d); chk("R11", "read word 5", d, 32'h0000_1234);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    tamp_en = 3'b000; tamp_pin[0] = 1'b1; step(8);
    chk("R1", "disabled input flag", 32'(tamp_flag), 0);
    tamp_pin[0] = 1'b0; step(4);
    rd(3, d); chk("R1", "bank kept with input disabled", d, 32'hA5A5_0F0F);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    tamp_en[0] = 1'b1; tamp_level[0] = 1'b0; irq_en = 1'b1; ts_on_tamp = 1'b1;
    step(2);
    tamp_pin[0] = 1'b1;
    step(2); chk("R2", "flag before third edge", 32'(tamp_flag), 0);
    step(1); chk("R2", "flag at third edge", 32'(tamp_flag), 32'b001);
    chk("R8", "ts_req with flag", 32'(ts_req), 1);
    chk("R7", "irq not yet", 32'(tamp_irq), 0);
    step(1); chk("R7", "irq one clock later", 32'(tamp_irq), 1);
    chk("R8", "ts_req single clock", 32'(ts_req), 0);
    rd(3, d); chk("R5", "word 3 erased", d, 0);
    rd(5, d); chk("R5", "word 5 erased", d, 0);
    flag_clr = 3'b001; step(1); flag_clr = '0;
    chk("R9", "flag cleared", 32'(tamp_flag), 0);
    step(1); chk("R7", "irq drops after clear", 32'(tamp_irq), 0);
    step(4); chk("R2", "held level does not retrigger", 32'(tamp_flag), 0);
    tamp_pin[0] = 1'b0; step(3);
  endtask

  task automatic t_level();
    logic [31:0] d;
    irq_en = 1'b0; ts_on_tamp = 1'b0;
    tamp_en[1] = 1'b1; tamp_level[1] = 1'b1; filt_sel = 2'b01;
    wr(2, 32'h77);
    tamp_pin[1] = 1'b1; step(3); tamp_pin[1] = 1'b0;
    step(6); chk("R3", "short pulse rejected", 32'(tamp_flag), 0);
    rd(2, d); chk("R3", "bank kept after short pulse", d, 32'h77);
    tamp_pin[1] = 1'b1;
    step(5); chk("R3", "N=4 before sample 4", 32'(tamp_flag), 0);
    step(1); chk("R3", "N=4 flag set", 32'(tamp_flag), 32'b010);
    chk("R8", "no ts_req when disabled", 32'(ts_req), 0);
    step(1); chk("R7", "irq stays low when masked", 32'(tamp_irq), 0);
    tamp_pin[1] = 1'b0; step(3); clear_all();
    filt_sel = 2'b10;
    tamp_pin[1] = 1'b1;
    step(9); chk("R3", "N=8 before sample 8", 32'(tamp_flag), 0);
    step(1); chk("R3", "N=8 flag set", 32'(tamp_flag), 32'b010);
    tamp_pin[1] = 1'b0; step(3); clear_all();
    tamp_en[1] = 1'b0;
  endtask

  task automatic t_polarity();
    tamp_pol[2] = 1'b0; tamp_pin[2] = 1'b1; step(4);
    tamp_en[2] = 1'b1; tamp_level[2] = 1'b0; step(4);
    chk("R4", "idle high no flag", 32'(tamp_flag), 0);
    tamp_pin[2] = 1'b0;
    step(3); chk("R4", "falling edge flags", 32'(tamp_flag), 32'b100);
    clear_all();
    tamp_pin[2] = 1'b1; step(4);
    chk("R4", "rising edge ignored", 32'(tamp_flag), 0);
    tamp_en[2] = 1'b0;
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(4, 32'hBEEF);
    tamp_pin[0] = 1'b1; step(2);
    bk_we = 1'b1; bk_addr = 3'd4; bk_wdata = 32'hCAFE;
    step(1); bk_we = 1'b0;
    chk("R6", "flag at collision", 32'(tamp_flag), 32'b001);
    rd(4, d); chk("R6", "colliding write dropped", d, 0);
    tamp_pin[0] = 1'b0; step(3); clear_all();
  endtask

  task automatic t_setwins();
    tamp_pin[0] = 1'b1; step(2);
    flag_clr = 3'b001; step(1); flag_clr = '0;
    chk("R9", "set beats clear", 32'(tamp_flag), 32'b001);
    tamp_pin[0] = 1'b0; step(3);
  endtask

  task automatic t_resets();
    logic [31:0] d;
    wr(1, 32'h55);
    sys_rst = 1'b1; step(2); sys_rst = 1'b0;
    chk("R10", "flags cleared by sys_rst", 32'(tamp_flag), 0);
    chk("R10", "irq cleared by sys_rst", 32'(tamp_irq), 0);
    rd(1, d); chk("R10", "word kept over sys_rst", d, 32'h55);
    por_rst = 1'b1; step(2); por_rst = 1'b0;
    rd(1, d); chk("R10", "word cleared by por_rst", d, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    por_rst = 1'b1; sys_rst = 1'b1;
    tamp_pin = '0; tamp_en = '0; tamp_pol = '1; tamp_level = '0; flag_clr = '0;
    filt_sel = 2'b00; samp_tick = 1'b1; irq_en = 1'b0; ts_on_tamp = 1'b0;
    bk_we = 1'b0; bk_addr = '0; bk_wdata = '0;
    t_reset();
    t_bank();
    t_disabled();
    t_edge();
    t_level();
    t_polarity();
    t_collide();
    t_setwins();
    t_resets();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule